// File: doc/BRIEF.md
# Packed Signed-Count Lane Rotator

This datapath unit takes a 128-bit source vector and splits it into four independent 32-bit lanes. It rotates each lane by a signed 8-bit count. The sign of the count selects the direction: a non-negative count rotates toward the most significant bit, and a negative count rotates toward the least significant bit. Bits that leave one end of a lane re-enter at the other end of that same lane. No bit ever moves into a neighbouring lane.

A mode input picks where the counts come from. In broadcast mode, the single immediate byte `imm_count` applies to all four lanes. In per-lane mode, lane *n* takes its count from bits [7:0] of lane *n* of `cnt_vec`. The rotated lanes form the low half of a 256-bit destination image, and the upper half is always zero. One register stage carries the result. An output state machine has two states, `OUT_IDLE` (nothing new) and `OUT_LOADED` (a fresh result is presented). It moves to `OUT_LOADED` on any cycle with `valid_in` high, and to `OUT_IDLE` on any cycle without it. Reset forces `OUT_IDLE`. The unit has no flag outputs.

Top module: `lane_rot_unit`

## Requirements
- R1: Each 32-bit lane `src_vec[32n+31:32n]` is rotated on its own into `dst_vec[32n+31:32n]`, so the number of set bits in each lane is preserved and no bit crosses a lane boundary.
- R2: A count with bit 7 clear rotates the lane left: bit i moves to bit (i+k) mod 32, and the MSB wraps to the LSB.
- R3: A count with bit 7 set (two's complement negative) rotates the lane right by its magnitude: bit i moves to bit (i-k) mod 32, and the LSB wraps to the MSB.
- R4: The effective amount is the count's magnitude modulo 32. A count of 0 or any magnitude that is a multiple of 32 (for example 32, 64, -96) leaves the lane unchanged.
- R5: A count of -128 (8'h80) leaves the lane unchanged.
- R6: With `count_mode` = 0 (broadcast), `imm_count` rotates all four lanes by the same amount, and `cnt_vec` has no effect on the result.
- R7: With `count_mode` = 1 (per-lane), lane n uses `cnt_vec[32n+7:32n]` as its count. `cnt_vec[32n+31:32n+8]` and `imm_count` have no effect on the result.
- R8: `dst_vec[255:128]` is always zero.
- R9: When `valid_in` is high at a rising edge, `valid_out` is high and `dst_vec` holds the result of those inputs after that edge. This holds on back-to-back cycles.
- R10: At a rising edge with `valid_in` low, `valid_out` goes low and `dst_vec` keeps its previous value whatever the other inputs do.
- R11: A rising edge with `rst` high clears `valid_out` and `dst_vec` to zero, even when `valid_in` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Inputs are sampled at this edge |
| count_mode | input | 1 | 0 = broadcast immediate count, 1 = per-lane counts from `cnt_vec` |
| src_vec | input | 128 | Four 32-bit source lanes |
| imm_count | input | 8 | Signed broadcast count |
| cnt_vec | input | 128 | Per-lane signed counts in the low byte of each 32-bit lane |
| valid_out | output | 1 | `dst_vec` carries a fresh result |
| dst_vec | output | 256 | Rotated lanes in [127:0], zero in [255:128] |

## Verification
Broadcast counts of +3, -5 and +31 run on lanes with distinct patterns. These separate left from right rotation and expose a lane that shares bits with a neighbour. A pattern with set bits at both lane edges shows whether wrapped bits stay inside their own lane. The counts 0, 32, 64, -96 and -128 separate a correct modulo-32 magnitude from a raw shift or a mishandled most-negative value. Per-lane runs use four different signed counts with junk in the upper 24 bits of each count lane and a conflicting immediate. They tell whether each lane reads its own low byte alone. Repeating a broadcast run with a different `cnt_vec` shows the unused operand is ignored.

// File: rtl/lane_rot_pkg.sv
package lane_rot_pkg;
    localparam int LANES    = 4;
    localparam int LANE_W   = 32;
    localparam int CNT_W    = 8;
    localparam int VEC_W    = LANES * LANE_W;
    localparam int DST_W    = 2 * VEC_W;

    typedef enum logic {
        CNT_BROADCAST = 1'b0,
        CNT_PER_LANE  = 1'b1
    } cnt_mode_e;

    typedef enum logic {
        OUT_IDLE   = 1'b0,
        OUT_LOADED = 1'b1
    } out_state_e;
endpackage

// File: rtl/lane_rot_count_sel.sv
module lane_rot_count_sel #(
    parameter int LANES  = 4,
    parameter int LANE_W = 32,
    parameter int CNT_W  = 8,
    localparam int VEC_W = LANES * LANE_W
) (
    input  lane_rot_pkg::cnt_mode_e mode,
    input  logic [CNT_W-1:0]        imm_count,
    input  logic [VEC_W-1:0]        cnt_vec,
    output logic [LANES*CNT_W-1:0]  lane_cnt
);
    logic [LANES-1:0] hi_bits_unused;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [CNT_W-1:0] own_byte;
        assign own_byte          = cnt_vec[l*LANE_W +: CNT_W];
        assign hi_bits_unused[l] = ^cnt_vec[l*LANE_W+CNT_W +: LANE_W-CNT_W];

        always_comb begin
            unique case (mode)
                lane_rot_pkg::CNT_BROADCAST: lane_cnt[l*CNT_W +: CNT_W] = imm_count;
                lane_rot_pkg::CNT_PER_LANE:  lane_cnt[l*CNT_W +: CNT_W] = own_byte;
                default:                     lane_cnt[l*CNT_W +: CNT_W] = imm_count;
            endcase
        end
    end
endmodule

// File: rtl/lane_rot_lane.sv
module lane_rot_lane #(
    parameter int LANE_W = 32,
    parameter int CNT_W  = 8,
    localparam int SHW   = $clog2(LANE_W)
) (
    input  logic [LANE_W-1:0] din,
    input  logic [CNT_W-1:0]  cnt,
    output logic [LANE_W-1:0] dout
);
    logic             go_right;
    logic [CNT_W-1:0] mag;
    logic [SHW-1:0]   amt;
    logic             mag_hi_unused;

    assign go_right      = cnt[CNT_W-1];
    assign mag           = go_right ? (~cnt + 1'b1) : cnt;
    assign amt           = mag[SHW-1:0];
    assign mag_hi_unused = ^mag[CNT_W-1:SHW];

    logic [LANE_W-1:0] stage [SHW+1];
    assign stage[0] = din;

    for (genvar s = 0; s < SHW; s++) begin : g_stage
        localparam int STEP = 1 << s;
        logic [LANE_W-1:0] rl;
        logic [LANE_W-1:0] rr;
        assign rl = {stage[s][LANE_W-1-STEP:0], stage[s][LANE_W-1:LANE_W-STEP]};
        assign rr = {stage[s][STEP-1:0], stage[s][LANE_W-1:STEP]};
        assign stage[s+1] = amt[s] ? (go_right ? rr : rl) : stage[s];
    end

    assign dout = stage[SHW];
endmodule

// File: rtl/lane_rot_out_stage.sv
module lane_rot_out_stage #(
    parameter int VEC_W = 128,
    localparam int DST_W = 2 * VEC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid_in,
    input  logic [VEC_W-1:0] rot_vec,
    output logic             valid_out,
    output logic [DST_W-1:0] dst_vec
);
    import lane_rot_pkg::*;

    out_state_e state_q, state_d;
    logic [VEC_W-1:0] res_q;

    always_comb begin
        unique case (state_q)
            OUT_IDLE:   state_d = valid_in ? OUT_LOADED : OUT_IDLE;
            OUT_LOADED: state_d = valid_in ? OUT_LOADED : OUT_IDLE;
            default:    state_d = OUT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= OUT_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst)           res_q <= '0;
        else if (valid_in) res_q <= rot_vec;
    end

    always_comb begin
        unique case (state_q)
            OUT_IDLE:   valid_out = 1'b0;
            OUT_LOADED: valid_out = 1'b1;
            default:    valid_out = 1'b0;
        endcase
        dst_vec = {{VEC_W{1'b0}}, res_q};
    end
endmodule

// File: rtl/lane_rot_unit.sv
module lane_rot_unit #(
    parameter int LANES  = lane_rot_pkg::LANES,
    parameter int LANE_W = lane_rot_pkg::LANE_W,
    parameter int CNT_W  = lane_rot_pkg::CNT_W,
    localparam int VEC_W = LANES * LANE_W,
    localparam int DST_W = 2 * VEC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid_in,
    input  logic             count_mode,
    input  logic [VEC_W-1:0] src_vec,
    input  logic [CNT_W-1:0] imm_count,
    input  logic [VEC_W-1:0] cnt_vec,
    output logic             valid_out,
    output logic [DST_W-1:0] dst_vec
);
    lane_rot_pkg::cnt_mode_e mode;
    logic [LANES*CNT_W-1:0]  lane_cnt;
    logic [VEC_W-1:0]        rot_vec;

    assign mode = lane_rot_pkg::cnt_mode_e'(count_mode);

    lane_rot_count_sel #(.LANES(LANES), .LANE_W(LANE_W), .CNT_W(CNT_W)) u_sel (
        .mode      (mode),
        .imm_count (imm_count),
        .cnt_vec   (cnt_vec),
        .lane_cnt  (lane_cnt)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        lane_rot_lane #(.LANE_W(LANE_W), .CNT_W(CNT_W)) u_lane (
            .din  (src_vec[l*LANE_W +: LANE_W]),
            .cnt  (lane_cnt[l*CNT_W +: CNT_W]),
            .dout (rot_vec[l*LANE_W +: LANE_W])
        );
    end

    lane_rot_out_stage #(.VEC_W(VEC_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .valid_in  (valid_in),
        .rot_vec   (rot_vec),
        .valid_out (valid_out),
        .dst_vec   (dst_vec)
    );
endmodule

// File: rtl/lane_rot_unit_chk.sv
module lane_rot_unit_chk #(
    parameter int LANES  = 4,
    parameter int LANE_W = 32,
    parameter int CNT_W  = 8,
    localparam int VEC_W = LANES * LANE_W,
    localparam int DST_W = 2 * VEC_W
) (
    input logic             clk,
    input logic             rst,
    input logic             valid_in,
    input logic             count_mode,
    input logic [VEC_W-1:0] src_vec,
    input logic [CNT_W-1:0] imm_count,
    input logic             valid_out,
    input logic [DST_W-1:0] dst_vec
);
    localparam int SHW = $clog2(LANE_W);

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        dst_vec[DST_W-1:VEC_W] == '0); // R8

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        ($past(valid_in) && !$past(rst)) |-> valid_out); // R9

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!$past(valid_in) && !$past(rst)) |-> (!valid_out && $stable(dst_vec))); // R10

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> (!valid_out && dst_vec == '0)); // R11

    AST_ZERO_PASS: assert property (@(posedge clk) disable iff (rst)
        ($past(valid_in) && !$past(rst) && !$past(count_mode) && $past(imm_count[SHW-1:0]) == '0)
        |-> dst_vec[VEC_W-1:0] == $past(src_vec)); // R4

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        AST_LANE_BITS: assert property (@(posedge clk) disable iff (rst)
            ($past(valid_in) && !$past(rst))
            |-> $countones(dst_vec[l*LANE_W +: LANE_W]) == $countones($past(src_vec[l*LANE_W +: LANE_W]))); // R1
    end
endmodule

bind lane_rot_unit lane_rot_unit_chk #(.LANES(LANES), .LANE_W(LANE_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .valid_in   (valid_in),
    .count_mode (count_mode),
    .src_vec    (src_vec),
    .imm_count  (imm_count),
    .valid_out  (valid_out),
    .dst_vec    (dst_vec)
);

// File: tb/lane_rot_unit_bench.sv
`timescale 1ns/1ps
module lane_rot_unit_bench;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         valid_in = 1'b0;
    logic         count_mode = 1'b0;
    logic [127:0] src_vec = '0;
    logic [7:0]   imm_count = '0;
    logic [127:0] cnt_vec = '0;
    logic         valid_out;
    logic [255:0] dst_vec;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    lane_rot_unit u_lane_rot_unit (
        .clk        (clk),
        .rst        (rst),
        .valid_in   (valid_in),
        .count_mode (count_mode),
        .src_vec    (src_vec),
        .imm_count  (imm_count),
        .cnt_vec    (cnt_vec),
        .valid_out  (valid_out),
        .dst_vec    (dst_vec)
    );

    function automatic logic [31:0] ref_rot(input logic [31:0] v, input logic [7:0] c);
        logic [31:0] r;
        int n;
        r = v;
        n = c[7] ? (256 - int'(c)) : int'(c);
        for (int k = 0; k < n; k++)
            r = c[7] ? {r[0], r[31:1]} : {r[30:0], r[31]};
        return r;
    endfunction

    function automatic logic [127:0] ref_vec(input logic m, input logic [127:0] s,
                                             input logic [7:0] imm, input logic [127:0] cv);
        logic [127:0] o;
        for (int l = 0; l < 4; l++)
            o[l*32 +: 32] = ref_rot(s[l*32 +: 32], m ? cv[l*32 +: 8] : imm);
        return o;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic m, input logic [127:0] s, input logic [7:0] imm, input logic [127:0] cv);
        @(negedge clk);
        valid_in = 1'b1; count_mode = m; src_vec = s; imm_count = imm; cnt_vec = cv;
        @(negedge clk);
        valid_in = 1'b0;
    endtask

    task automatic run_op(input logic m, input logic [127:0] s, input logic [7:0] imm,
                          input logic [127:0] cv, input string tag);
        logic [127:0] e;
        e = ref_vec(m, s, imm, cv);
        apply(m, s, imm, cv);
        chk(valid_out == 1'b1, {tag, " valid R9"}, {255'b0, valid_out}, 256'd1);
        chk(dst_vec[127:0] == e, tag, dst_vec, {128'b0, e});
        chk(dst_vec[255:128] == '0, {tag, " upper R8"}, dst_vec, {128'b0, e});
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(valid_out == 1'b0 && dst_vec == '0, "R11 reset state", dst_vec, '0);
    endtask

    task automatic t_directions();
        run_op(1'b0, 128'h01234567_89abcdef_f0e1d2c3_80000001, 8'd3, '0, "R2 left 3");
        run_op(1'b0, 128'h01234567_89abcdef_f0e1d2c3_80000001, 8'hfb, '0, "R3 right 5");
        run_op(1'b0, 128'hdeadbeef_00000001_80000000_12345678, 8'd31, '0, "R2 left 31");
        run_op(1'b0, 128'h80000001_80000001_80000001_80000001, 8'd1, '0, "R1 lane edge left");
        run_op(1'b0, 128'h80000001_00000000_ffffffff_00000001, 8'hff, '0, "R1 lane edge right");
        chk(dst_vec[127:0] == 128'hc0000000_00000000_ffffffff_80000000, "R1 no crossing",
            dst_vec, {128'b0, 128'hc0000000_00000000_ffffffff_80000000});
    endtask

    task automatic t_modulo();
        logic [127:0] s;
        s = 128'h13579bdf_2468ace0_a5a5f00f_0badc0de;
        run_op(1'b0, s, 8'd0,  '0, "R4 count 0");
        chk(dst_vec[127:0] == s, "R4 zero unchanged", dst_vec, {128'b0, s});
        run_op(1'b0, s, 8'd32, '0, "R4 count 32");
        chk(dst_vec[127:0] == s, "R4 32 unchanged", dst_vec, {128'b0, s});
        run_op(1'b0, s, 8'd64, '0, "R4 count 64");
        run_op(1'b0, s, 8'ha0, '0, "R4 count -96");
        chk(dst_vec[127:0] == s, "R4 -96 unchanged", dst_vec, {128'b0, s});
        run_op(1'b0, s, 8'd37, '0, "R4 count 37");
        run_op(1'b0, s, 8'h80, '0, "R5 count -128");
        chk(dst_vec[127:0] == s, "R5 -128 unchanged", dst_vec, {128'b0, s});
    endtask

    task automatic t_broadcast_ignores_vec();
        logic [127:0] s;
        logic [127:0] first;
        s = 128'hcafef00d_00ff00ff_76543210_fedcba98;
        run_op(1'b0, s, 8'd7, 128'h05050505_fbfbfbfb_11111111_22222222, "R6 broadcast A");
        first = dst_vec[127:0];
        run_op(1'b0, s, 8'd7, 128'hffffffff_00000000_8080_8080_0101_0101, "R6 broadcast B");
        chk(dst_vec[127:0] == first, "R6 cnt_vec ignored", dst_vec, {128'b0, first});
    endtask

    task automatic t_per_lane();
        logic [127:0] s;
        logic [127:0] first;
        s = 128'h89abcdef_01234567_f00ff00f_00000003;
        run_op(1'b1, s, 8'd9, 128'h00000004_000000f8_00000080_00000021, "R7 per lane A");
        first = dst_vec[127:0];
        run_op(1'b1, s, 8'h85, 128'habcdef04_123456f8_ffffff80_7e7e7e21, "R7 per lane junk hi");
        chk(dst_vec[127:0] == first, "R7 hi bits and imm ignored", dst_vec, {128'b0, first});
    endtask

    task automatic t_hold_and_stream();
        logic [127:0] held;
        logic [127:0] e1;
        logic [127:0] e2;
        run_op(1'b0, 128'h11223344_55667788_99aabbcc_ddeeff00, 8'd12, '0, "R9 single");
        held = dst_vec[127:0];
        @(negedge clk);
        src_vec = ~src_vec; imm_count = 8'd5; count_mode = 1'b1; cnt_vec = '1;
        @(negedge clk);
        chk(valid_out == 1'b0, "R10 valid low idle", {255'b0, valid_out}, '0);
        chk(dst_vec[127:0] == held, "R10 result held", dst_vec, {128'b0, held});
        e1 = ref_vec(1'b0, 128'h00000001_00000002_00000004_00000008, 8'd1, '0);
        e2 = ref_vec(1'b0, 128'h00000010_00000020_00000040_00000080, 8'hfe, '0);
        @(negedge clk);
        valid_in = 1'b1; count_mode = 1'b0; imm_count = 8'd1;
        src_vec = 128'h00000001_00000002_00000004_00000008;
        @(negedge clk);
        chk(valid_out && dst_vec[127:0] == e1, "R9 stream first", dst_vec, {128'b0, e1});
        imm_count = 8'hfe; src_vec = 128'h00000010_00000020_00000040_00000080;
        @(negedge clk);
        chk(valid_out && dst_vec[127:0] == e2, "R9 stream second", dst_vec, {128'b0, e2});
        valid_in = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset_mid();
        run_op(1'b0, 128'hffff0000_ffff0000_ffff0000_ffff0000, 8'd4, '0, "R11 preload");
        @(negedge clk);
        rst = 1'b1; valid_in = 1'b1;
        @(negedge clk);
        chk(valid_out == 1'b0 && dst_vec == '0, "R11 reset beats valid", dst_vec, '0);
        rst = 1'b0; valid_in = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_directions();
        t_modulo();
        t_broadcast_ignores_vec();
        t_per_lane();
        t_hold_and_stream();
        t_reset_mid();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule